// File: doc/BRIEF.md
# Two-Level Encryption Counter Manager

This block keeps the counters that feed counter-mode memory encryption. Each memory block has a narrow counter, and each page has a wide counter. When a block is written, the manager bumps that block's counter. One cycle later it presents the seed from which the one-time pad for that write is formed. The seed is the page counter, then the block counter, then the block address.

A block counter that already holds its largest value cannot be bumped, so a write to it starts a page refresh instead:

- The page counter is raised by one.
- A sequencer visits every block of the page in ascending order.
- For each block it reads the data from memory and removes the old pad.
- It then applies a pad built from the new page counter and a zero block counter, and writes the data back.
- It clears each block counter as that block is written back.

When the walk finishes, the block whose write started it takes the value 1 and its seed is presented. The memory and the pad generator are reached through valid/ready request ports with single-cycle response strobes.

A separate lookup port reports the present seed of any block without altering any counter. While a refresh runs, the block raises a busy flag and refuses new writes.

Top module: `encctr_mgr`

## Requirements
- R1: After reset every page counter and every block counter is zero, so a lookup of any address returns a seed whose page and block fields are zero.
- R2: A write accepted (wr_valid and wr_ready high at a rising edge) to a block whose counter is below its maximum (127 for the default 7-bit width) raises that counter by one. In the following cycle seed_valid is high for one cycle with seed = {page counter, new block counter, address}. The page counter occupies the top PG_W bits, the block counter the next BLK_W bits, and the address the low bits.
- R3: An accepted write to a block whose counter is at its maximum raises the page counter of that block's page by one and starts a refresh walk. busy is high and wr_ready is low from the next cycle until the walk has ended.
- R4: During a walk, every block of the page is read, XORed with the pad returned for seed {old page counter, old block counter, address}, then XORed with the pad returned for seed {new page counter, 0, address}, and written back to the same address.
- R5: When the walk ends, every block counter of that page is zero except the block that started the walk, which is 1. seed_valid then pulses with seed {new page counter, 1, address}.
- R6: A walk leaves the counters of every other page unchanged.
- R7: A lookup request returns lk_seed_valid and the seed of lk_addr in the next cycle and changes no counter.
- R8: No seed presented on the write seed output has a zero block field, so write seeds never coincide with the seeds used to re-encrypt during a walk.
- R9: A memory or pad request that is not accepted is held, with address, direction and seed stable, until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Block write request |
| wr_ready | output | 1 | Write may be accepted (low during a walk) |
| wr_addr | input | AW (8) | Block address of the write: page index then block offset |
| seed_valid | output | 1 | One-cycle strobe for a new write seed |
| seed | output | SEED_W (79) | Seed {page counter, block counter, address} |
| busy | output | 1 | Page refresh walk in progress |
| lk_valid | input | 1 | Seed lookup request |
| lk_addr | input | AW (8) | Address to look up |
| lk_seed_valid | output | 1 | Lookup result strobe |
| lk_seed | output | SEED_W (79) | Current seed of the looked-up block |
| mem_req_valid | output | 1 | Memory request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = write back, 0 = read |
| mem_req_addr | output | AW (8) | Memory block address |
| mem_req_wdata | output | DATA_W (64) | Re-encrypted block data |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_rdata | input | DATA_W (64) | Read data |
| crypt_req_valid | output | 1 | Pad request |
| crypt_req_ready | input | 1 | Pad generator accepts the request |
| crypt_req_seed | output | SEED_W (79) | Seed the pad is formed from |
| crypt_rsp_valid | input | 1 | Pad strobe |
| crypt_rsp_pad | input | DATA_W (64) | Pad value |

## Verification
Repeated writes to one block carry its counter from 1 up to 127, which shows plain increments apart from the overflow path. The write after those starts a walk. The walk is checked against a bench memory holding data transformed with a model pad function, so a wrong old seed, new seed, or block order gives different data. Randomly addressed writes and lookups spread over all pages show whether a walk disturbs neighbouring pages and whether lookups leave counters alone. A walk on the last block of the last page covers the address boundary. Random ready signals on the memory and pad ports test that stalled requests are held.

// File: rtl/encctr_pkg.sv
`timescale 1ns/1ps
package encctr_pkg;

   // walk sequencer states; one pass per block of the page
   typedef enum logic [3:0] {
      WK_IDLE,
      WK_RD,     // issue memory read
      WK_RDW,    // wait for read data
      WK_OP,     // request pad of old seed
      WK_OPW,    // wait old pad
      WK_NP,     // request pad of new seed
      WK_NPW,    // wait new pad
      WK_WR,     // issue memory write back
      WK_FIN     // walk complete, one cycle
   } walk_st_e;

endpackage

// File: rtl/encctr_bank.sv
`timescale 1ns/1ps
module encctr_bank #(
   parameter int BLK_W       = 7,
   parameter int PG_W        = 64,
   parameter int BLKS_PER_PG = 64,
   parameter int NUM_PG      = 4,
   localparam int NBLK  = BLKS_PER_PG * NUM_PG,
   localparam int OFF_W = $clog2(BLKS_PER_PG),
   localparam int PGI_W = $clog2(NUM_PG),
   localparam int AW    = OFF_W + PGI_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AW-1:0]     a_addr,
   output logic [BLK_W-1:0]  a_blk,
   output logic [PG_W-1:0]   a_pg,
   input  logic [AW-1:0]     b_addr,
   output logic [BLK_W-1:0]  b_blk,
   output logic [PG_W-1:0]   b_pg,
   input  logic              blk_we,
   input  logic [AW-1:0]     blk_waddr,
   input  logic [BLK_W-1:0]  blk_wdata,
   input  logic              pg_we,
   input  logic [PGI_W-1:0]  pg_widx,
   input  logic [PG_W-1:0]   pg_wdata
);

   logic [BLK_W-1:0] blk_q [NBLK];
   logic [PG_W-1:0]  pg_arr [NUM_PG];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NBLK; i++) blk_q[i] <= '0;
      end else if (blk_we) begin
         blk_q[blk_waddr] <= blk_wdata;
      end
   end

   for (genvar p = 0; p < NUM_PG; p++) begin : g_pg
      logic [PG_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                q <= '0;
         else if (pg_we && pg_widx == PGI_W'(p))    q <= pg_wdata;
      end
      assign pg_arr[p] = q;
   end

   assign a_blk = blk_q[a_addr];
   assign a_pg  = pg_arr[a_addr[AW-1:OFF_W]];
   assign b_blk = blk_q[b_addr];
   assign b_pg  = pg_arr[b_addr[AW-1:OFF_W]];

   // R7
   ctr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!blk_we && !pg_we) ##1 $stable(b_addr) |-> $stable(b_blk) && $stable(b_pg));

endmodule

// File: rtl/encctr_walker.sv
`timescale 1ns/1ps
module encctr_walker
   import encctr_pkg::*;
#(
   parameter int BLK_W       = 7,
   parameter int PG_W        = 64,
   parameter int BLKS_PER_PG = 64,
   parameter int NUM_PG      = 4,
   parameter int DATA_W      = 64,
   localparam int OFF_W  = $clog2(BLKS_PER_PG),
   localparam int PGI_W  = $clog2(NUM_PG),
   localparam int AW     = OFF_W + PGI_W,
   localparam int SEED_W = PG_W + BLK_W + AW
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [PGI_W-1:0]   start_pg,
   input  logic [PG_W-1:0]    start_old_pg,
   output logic               busy,
   output logic               fin,
   output logic [AW-1:0]      ctr_addr,
   input  logic [BLK_W-1:0]   ctr_blk,
   output logic               clr_we,
   output logic [AW-1:0]      clr_addr,
   output logic               mem_req_valid,
   input  logic               mem_req_ready,
   output logic               mem_req_we,
   output logic [AW-1:0]      mem_req_addr,
   output logic [DATA_W-1:0]  mem_req_wdata,
   input  logic               mem_rsp_valid,
   input  logic [DATA_W-1:0]  mem_rsp_rdata,
   output logic               crypt_req_valid,
   input  logic               crypt_req_ready,
   output logic [SEED_W-1:0]  crypt_req_seed,
   input  logic               crypt_rsp_valid,
   input  logic [DATA_W-1:0]  crypt_rsp_pad
);

   localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(BLKS_PER_PG - 1);

   walk_st_e          st;
   logic [PGI_W-1:0]  pg_idx;
   logic [PG_W-1:0]   old_pg;
   logic [OFF_W-1:0]  off;
   logic [DATA_W-1:0] dat_q;
   logic [AW-1:0]     cur_addr;
   logic [PG_W-1:0]   new_pg;

   assign cur_addr = {pg_idx, off};
   assign new_pg   = old_pg + PG_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= WK_IDLE;
         pg_idx <= '0;
         old_pg <= '0;
         off    <= '0;
         dat_q  <= '0;
      end else begin
         case (st)
            WK_IDLE: if (start) begin
               st     <= WK_RD;
               pg_idx <= start_pg;
               old_pg <= start_old_pg;
               off    <= '0;
            end
            WK_RD:   if (mem_req_ready) st <= WK_RDW;
            WK_RDW:  if (mem_rsp_valid) begin
               dat_q <= mem_rsp_rdata;
               st    <= WK_OP;
            end
            WK_OP:   if (crypt_req_ready) st <= WK_OPW;
            WK_OPW:  if (crypt_rsp_valid) begin
               dat_q <= dat_q ^ crypt_rsp_pad;
               st    <= WK_NP;
            end
            WK_NP:   if (crypt_req_ready) st <= WK_NPW;
            WK_NPW:  if (crypt_rsp_valid) begin
               dat_q <= dat_q ^ crypt_rsp_pad;
               st    <= WK_WR;
            end
            WK_WR:   if (mem_req_ready) begin
               if (off == LAST_OFF) st <= WK_FIN;
               else begin
                  off <= off + OFF_W'(1);
                  st  <= WK_RD;
               end
            end
            WK_FIN:  st <= WK_IDLE;
            default: st <= WK_IDLE;
         endcase
      end
   end

   assign busy          = (st != WK_IDLE);
   assign fin           = (st == WK_FIN);
   assign ctr_addr      = cur_addr;
   assign mem_req_valid = (st == WK_RD) || (st == WK_WR);
   assign mem_req_we    = (st == WK_WR);
   assign mem_req_addr  = cur_addr;
   assign mem_req_wdata = dat_q;
   assign clr_we        = (st == WK_WR) && mem_req_ready;
   assign clr_addr      = cur_addr;

   assign crypt_req_valid = (st == WK_OP) || (st == WK_NP);
   assign crypt_req_seed  = (st == WK_NP) ? {new_pg, BLK_W'(0), cur_addr}
                                          : {old_pg, ctr_blk, cur_addr};

   // R9
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=>
         mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we));

   // R9
   crypt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      crypt_req_valid && !crypt_req_ready |=>
         crypt_req_valid && $stable(crypt_req_seed));

   // R4
   wb_after_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req_we) |-> $past(crypt_rsp_valid));

endmodule

// File: rtl/encctr_mgr.sv
`timescale 1ns/1ps
module encctr_mgr #(
   parameter int BLK_W       = 7,
   parameter int PG_W        = 64,
   parameter int BLKS_PER_PG = 64,
   parameter int NUM_PG      = 4,
   parameter int DATA_W      = 64,
   parameter bit LK_REG      = 1'b1,
   localparam int OFF_W  = $clog2(BLKS_PER_PG),
   localparam int PGI_W  = $clog2(NUM_PG),
   localparam int AW     = OFF_W + PGI_W,
   localparam int SEED_W = PG_W + BLK_W + AW
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_valid,
   output logic               wr_ready,
   input  logic [AW-1:0]      wr_addr,
   output logic               seed_valid,
   output logic [SEED_W-1:0]  seed,
   output logic               busy,
   input  logic               lk_valid,
   input  logic [AW-1:0]      lk_addr,
   output logic               lk_seed_valid,
   output logic [SEED_W-1:0]  lk_seed,
   output logic               mem_req_valid,
   input  logic               mem_req_ready,
   output logic               mem_req_we,
   output logic [AW-1:0]      mem_req_addr,
   output logic [DATA_W-1:0]  mem_req_wdata,
   input  logic               mem_rsp_valid,
   input  logic [DATA_W-1:0]  mem_rsp_rdata,
   output logic               crypt_req_valid,
   input  logic               crypt_req_ready,
   output logic [SEED_W-1:0]  crypt_req_seed,
   input  logic               crypt_rsp_valid,
   input  logic [DATA_W-1:0]  crypt_rsp_pad
);

   localparam logic [BLK_W-1:0] BLK_MAX = '1;

   // elaboration-time parameter checks
   if (BLK_W < 2) begin : g_bad_blk_w
      $error("block counter width must be at least 2");
   end
   if (PG_W <= BLK_W) begin : g_bad_pg_w
      $error("page counter must be wider than block counter");
   end
   if (NUM_PG < 2 || (NUM_PG & (NUM_PG - 1)) != 0) begin : g_bad_num_pg
      $error("page count must be a power of two, at least 2");
   end
   if (BLKS_PER_PG < 2 || (BLKS_PER_PG & (BLKS_PER_PG - 1)) != 0) begin : g_bad_bpp
      $error("blocks per page must be a power of two, at least 2");
   end
   if (DATA_W < 1) begin : g_bad_data_w
      $error("data width must be positive");
   end

   logic [AW-1:0]     a_addr, b_addr;
   logic [BLK_W-1:0]  a_blk, b_blk;
   logic [PG_W-1:0]   a_pg, b_pg;
   logic              blk_we, pg_we;
   logic [AW-1:0]     blk_waddr;
   logic [BLK_W-1:0]  blk_wdata;
   logic [PGI_W-1:0]  pg_widx;
   logic [PG_W-1:0]   pg_wdata;

   logic              wk_busy, wk_fin, wk_clr_we, wk_start;
   logic [AW-1:0]     wk_ctr_addr, wk_clr_addr;

   logic              wr_fire, at_max;
   logic [AW-1:0]     pend_addr;
   logic              seed_v_q;
   logic [SEED_W-1:0] seed_q;

   encctr_bank #(
      .BLK_W(BLK_W), .PG_W(PG_W), .BLKS_PER_PG(BLKS_PER_PG), .NUM_PG(NUM_PG)
   ) u_bank (
      .clk(clk), .rst_n(rst_n),
      .a_addr(a_addr), .a_blk(a_blk), .a_pg(a_pg),
      .b_addr(b_addr), .b_blk(b_blk), .b_pg(b_pg),
      .blk_we(blk_we), .blk_waddr(blk_waddr), .blk_wdata(blk_wdata),
      .pg_we(pg_we), .pg_widx(pg_widx), .pg_wdata(pg_wdata)
   );

   encctr_walker #(
      .BLK_W(BLK_W), .PG_W(PG_W), .BLKS_PER_PG(BLKS_PER_PG),
      .NUM_PG(NUM_PG), .DATA_W(DATA_W)
   ) u_walk (
      .clk(clk), .rst_n(rst_n),
      .start(wk_start), .start_pg(wr_addr[AW-1:OFF_W]), .start_old_pg(a_pg),
      .busy(wk_busy), .fin(wk_fin),
      .ctr_addr(wk_ctr_addr), .ctr_blk(a_blk),
      .clr_we(wk_clr_we), .clr_addr(wk_clr_addr),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
      .mem_req_wdata(mem_req_wdata),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
      .crypt_req_valid(crypt_req_valid), .crypt_req_ready(crypt_req_ready),
      .crypt_req_seed(crypt_req_seed),
      .crypt_rsp_valid(crypt_rsp_valid), .crypt_rsp_pad(crypt_rsp_pad)
   );

   // counter port A: walker while walking, pending block at the end, writer otherwise
   always_comb begin
      if (wk_fin)       a_addr = pend_addr;
      else if (wk_busy) a_addr = wk_ctr_addr;
      else              a_addr = wr_addr;
   end

   assign wr_ready = !wk_busy;
   assign wr_fire  = wr_valid && wr_ready;
   assign at_max   = (a_blk == BLK_MAX);
   assign wk_start = wr_fire && at_max;

   always_comb begin
      blk_we    = 1'b0;
      blk_waddr = wr_addr;
      blk_wdata = a_blk + BLK_W'(1);
      if (wk_clr_we) begin
         blk_we    = 1'b1;
         blk_waddr = wk_clr_addr;
         blk_wdata = '0;
      end else if (wk_fin) begin
         blk_we    = 1'b1;
         blk_waddr = pend_addr;
         blk_wdata = BLK_W'(1);
      end else if (wr_fire && !at_max) begin
         blk_we    = 1'b1;
      end
   end

   assign pg_we    = wk_start;
   assign pg_widx  = wr_addr[AW-1:OFF_W];
   assign pg_wdata = a_pg + PG_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_addr <= '0;
         seed_v_q  <= 1'b0;
         seed_q    <= '0;
      end else begin
         if (wk_start) pend_addr <= wr_addr;
         seed_v_q <= (wr_fire && !at_max) || wk_fin;
         if (wk_fin)
            seed_q <= {a_pg, BLK_W'(1), pend_addr};
         else if (wr_fire && !at_max)
            seed_q <= {a_pg, a_blk + BLK_W'(1), wr_addr};
      end
   end

   assign seed_valid = seed_v_q;
   assign seed       = seed_q;
   assign busy       = wk_busy;

   // lookup port: registered or pass-through variant
   logic [SEED_W-1:0] lk_raw;
   assign b_addr = lk_addr;
   assign lk_raw = {b_pg, b_blk, lk_addr};

   if (LK_REG) begin : g_lk_reg
      logic              lk_v_q;
      logic [SEED_W-1:0] lk_s_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lk_v_q <= 1'b0;
            lk_s_q <= '0;
         end else begin
            lk_v_q <= lk_valid;
            if (lk_valid) lk_s_q <= lk_raw;
         end
      end
      assign lk_seed_valid = lk_v_q;
      assign lk_seed       = lk_s_q;
   end else begin : g_lk_comb
      assign lk_seed_valid = lk_valid;
      assign lk_seed       = lk_raw;
   end

   // R8
   seed_blk_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seed_valid |-> seed[AW +: BLK_W] != '0);

   // R3
   walk_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && wr_ready && at_max |=> busy && !wr_ready);

endmodule

// File: tb/encctr_mgr_bench.sv
`timescale 1ns/1ps
module encctr_mgr_bench;

   localparam int BLK_W = 7;
   localparam int PG_W  = 64;
   localparam int BPP   = 64;
   localparam int NPG   = 4;
   localparam int DW    = 64;
   localparam int NB    = BPP * NPG;
   localparam int AW    = 8;
   localparam int SW    = PG_W + BLK_W + AW;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic           rst_n;
   logic           wr_valid, wr_ready;
   logic [AW-1:0]  wr_addr;
   logic           seed_valid;
   logic [SW-1:0]  seed;
   logic           busy;
   logic           lk_valid;
   logic [AW-1:0]  lk_addr;
   logic           lk_seed_valid;
   logic [SW-1:0]  lk_seed;
   logic           mem_req_valid, mem_req_ready, mem_req_we;
   logic [AW-1:0]  mem_req_addr;
   logic [DW-1:0]  mem_req_wdata;
   logic           mem_rsp_valid;
   logic [DW-1:0]  mem_rsp_rdata;
   logic           crypt_req_valid, crypt_req_ready;
   logic [SW-1:0]  crypt_req_seed;
   logic           crypt_rsp_valid;
   logic [DW-1:0]  crypt_rsp_pad;

   encctr_mgr #(.BLK_W(BLK_W), .PG_W(PG_W), .BLKS_PER_PG(BPP), .NUM_PG(NPG),
                .DATA_W(DW)) u_encctr_mgr (
      .clk(clk), .rst_n(rst_n),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
      .seed_valid(seed_valid), .seed(seed), .busy(busy),
      .lk_valid(lk_valid), .lk_addr(lk_addr),
      .lk_seed_valid(lk_seed_valid), .lk_seed(lk_seed),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
      .mem_req_wdata(mem_req_wdata),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
      .crypt_req_valid(crypt_req_valid), .crypt_req_ready(crypt_req_ready),
      .crypt_req_seed(crypt_req_seed),
      .crypt_rsp_valid(crypt_rsp_valid), .crypt_rsp_pad(crypt_rsp_pad)
   );

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   logic [BLK_W-1:0] mblk [NB];
   logic [PG_W-1:0]  mpg  [NPG];
   logic [DW-1:0]    mem  [NB];
   logic [DW-1:0]    xmem [NB];

   function automatic logic [DW-1:0] pad_of(input logic [SW-1:0] s);
      logic [63:0] h;
      h = s[63:0] ^ {49'd0, s[SW-1:64]};
      h = h * 64'h9E37_79B9_7F4A_7C15;
      h = h ^ (h >> 31);
      h = h * 64'hBF58_476D_1CE4_E5B9;
      return h ^ (h >> 27);
   endfunction

   function automatic logic [SW-1:0] mk_seed(input logic [PG_W-1:0] p,
                                             input logic [BLK_W-1:0] b,
                                             input logic [AW-1:0] a);
      return {p, b, a};
   endfunction

   task automatic check(input bit ok, input string req,
                        input logic [SW-1:0] act, input logic [SW-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   // memory responder with random acceptance
   logic          m_acc, m_acc_we, m_stall;
   logic [AW-1:0] m_acc_a, m_stall_a;
   logic [DW-1:0] m_acc_d;
   initial begin
      mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_rdata = '0;
      m_acc = 1'b0; m_acc_we = 1'b0; m_acc_a = '0; m_acc_d = '0;
      m_stall = 1'b0; m_stall_a = '0;
      forever begin
         @(negedge clk);
         mem_rsp_valid = 1'b0;
         if (m_acc) begin
            if (m_acc_we) mem[m_acc_a] = m_acc_d;
            else begin
               mem_rsp_valid = 1'b1;
               mem_rsp_rdata = mem[m_acc_a];
            end
         end
         if (m_stall)  // R9: held request
            check(mem_req_valid && mem_req_addr == m_stall_a, "R9",
                  SW'(mem_req_addr), SW'(m_stall_a));
         mem_req_ready = ($urandom % 3) != 0;
         m_acc    = mem_req_valid && mem_req_ready;
         m_acc_we = mem_req_we;
         m_acc_a  = mem_req_addr;
         m_acc_d  = mem_req_wdata;
         m_stall   = mem_req_valid && !mem_req_ready;
         m_stall_a = mem_req_addr;
      end
   end

   // pad responder with random acceptance
   logic          c_acc, c_stall;
   logic [SW-1:0] c_acc_s, c_stall_s;
   initial begin
      crypt_req_ready = 1'b0; crypt_rsp_valid = 1'b0; crypt_rsp_pad = '0;
      c_acc = 1'b0; c_acc_s = '0; c_stall = 1'b0; c_stall_s = '0;
      forever begin
         @(negedge clk);
         crypt_rsp_valid = 1'b0;
         if (c_acc) begin
            crypt_rsp_valid = 1'b1;
            crypt_rsp_pad   = pad_of(c_acc_s);
         end
         if (c_stall)  // R9: held seed
            check(crypt_req_valid && crypt_req_seed == c_stall_s, "R9",
                  crypt_req_seed, c_stall_s);
         crypt_req_ready = ($urandom % 2) != 0;
         c_acc     = crypt_req_valid && crypt_req_ready;
         c_acc_s   = crypt_req_seed;
         c_stall   = crypt_req_valid && !crypt_req_ready;
         c_stall_s = crypt_req_seed;
      end
   end

   task automatic do_write(input logic [AW-1:0] a);
      bit            ovf;
      int            pgi, w;
      logic [SW-1:0] es;
      pgi = int'(a) / BPP;
      ovf = (mblk[a] == '1);
      if (ovf) begin
         for (int j = 0; j < BPP; j++) begin
            int b;
            b = pgi * BPP + j;
            xmem[b] = xmem[b] ^ pad_of(mk_seed(mpg[pgi], mblk[b], AW'(b)))
                              ^ pad_of(mk_seed(mpg[pgi] + 64'd1, '0, AW'(b)));
            mblk[b] = '0;
         end
         mpg[pgi] = mpg[pgi] + 64'd1;
         mblk[a]  = BLK_W'(1);
      end else begin
         mblk[a] = mblk[a] + BLK_W'(1);
      end
      es = mk_seed(mpg[pgi], mblk[a], a);
      wr_valid = 1'b1;
      wr_addr  = a;
      w = 0;
      while (!wr_ready && w < 5000) begin @(negedge clk); w++; end
      @(posedge clk);
      @(negedge clk);
      wr_valid = 1'b0;
      if (!ovf) begin
         check(seed_valid && seed == es, "R2", seed, es);
      end else begin
         check(busy && !wr_ready, "R3", SW'({busy, wr_ready}), SW'(2'b10));
         w = 0;
         while (!seed_valid && w < 20000) begin @(negedge clk); w++; end
         check(seed_valid && seed == es, "R5", seed, es);
         for (int j = 0; j < BPP; j++) begin
            int b;
            b = pgi * BPP + j;
            if (mem[b] != xmem[b])
               check(1'b0, "R4", SW'(mem[b]), SW'(xmem[b]));
         end
         check(1'b1, "R4", '0, '0);
      end
      check(seed[AW +: BLK_W] != '0, "R8", seed, es);
   endtask

   task automatic do_lookup(input logic [AW-1:0] a, input string req);
      logic [SW-1:0] es;
      es = mk_seed(mpg[int'(a) / BPP], mblk[a], a);
      lk_valid = 1'b1;
      lk_addr  = a;
      @(posedge clk);
      @(negedge clk);
      lk_valid = 1'b0;
      check(lk_seed_valid && lk_seed == es, req, lk_seed, es);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      rst_n = 1'b0; wr_valid = 1'b0; wr_addr = '0; lk_valid = 1'b0; lk_addr = '0;
      for (int i = 0; i < NB; i++) begin
         mblk[i] = '0;
         mem[i]  = {$urandom, $urandom};
         xmem[i] = mem[i];
      end
      for (int p = 0; p < NPG; p++) mpg[p] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      check(!busy && wr_ready && !seed_valid, "R1", SW'({busy, wr_ready}), SW'(2'b01));
      do_lookup(8'd0, "R1");
      do_lookup(8'd255, "R1");

      // R2 plain write, R7 lookups do not disturb counters
      do_write(8'd5);
      do_lookup(8'd5, "R7");
      do_lookup(8'd5, "R7");
      do_write(8'd5);
      check(seed[AW +: BLK_W] == 7'd2, "R7", seed, mk_seed(64'd0, 7'd2, 8'd5));

      // hammer block 5 to its maximum, then overflow: R3 R4 R5
      while (mblk[5] != '1) do_write(8'd5);
      do_write(8'd5);
      do_lookup(8'd6, "R5");
      do_lookup(8'd63, "R5");
      do_lookup(8'd64, "R6");
      do_lookup(8'd200, "R6");
      do_write(8'd6);

      // random writes and lookups
      for (int n = 0; n < 300; n++) begin
         logic [AW-1:0] ra;
         ra = AW'($urandom % NB);
         if ($urandom % 4 == 0) do_lookup(ra, "R7");
         else do_write(ra);
      end

      // boundary: last block of last page overflows
      while (mblk[255] != '1) do_write(8'd255);
      do_write(8'd255);
      do_lookup(8'd192, "R5");
      do_lookup(8'd191, "R6");
      do_lookup(8'd5, "R6");
      do_write(8'd255);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule